// File: doc/BRIEF.md
# Single-Issue Function Unit Dispatcher

This controller sits between an instruction decoder and a set of function units in a minimal in-order core. It takes one decoded instruction at a time. Each instruction carries a class bitmask with one bit per function unit. The controller finds the unit whose class bit is set. It sends that unit, and no other, a one-cycle issue strobe. It then refuses new work until the unit reports that it has finished. A unit counts as finished only when its busy line has gone high and then low again. The busy line must stay high through the unit's register writeback.

The default configuration serves five units: bit 0 arithmetic, bit 1 logical, bit 2 shift/rotate, bit 3 condition-register, and bit 4 branch. If the mask names several units, the lowest-numbered one is chosen. If the mask names none, the instruction is discarded and a one-cycle illegal-instruction flag is raised. Because only one unit is ever in flight, the core needs no dependency tracking.

Top module: `fu_dispatch`

## Requirements
- R1: After a synchronous reset, and whenever the controller is idle, `instReady` is 1, `unitIssue` is all zeros and `illegalInst` is 0. `instReady` is 0 in every other state.
- R2: An instruction is accepted on a clock edge where `instValid` and `instReady` are both 1. In the cycle after acceptance, `unitIssue` carries exactly one set bit for exactly one cycle.
- R3: Mask bit i selects unit i, where bit 0 is arithmetic, bit 1 logical, bit 2 shift/rotate, bit 3 condition-register and bit 4 branch. The issued bit is always the selected unit's bit.
- R4: When several mask bits are set, the lowest-numbered set bit wins.
- R5: After an issue, `instReady` stays 0 until the selected unit's busy bit has been sampled high on some edge and later sampled low. `instReady` returns to 1 in the cycle after the edge that samples busy low. While busy has not yet risen, the controller waits with no time limit.
- R6: The busy bits of units that were not selected have no effect on the controller.
- R7: An accepted instruction with an all-zero mask produces no issue. It raises `illegalInst` for exactly the one cycle after acceptance, with `instReady` at 0 during that cycle. `instReady` is 1 again in the cycle after that.
- R8: Asserting `rst` during any state returns the controller to idle at the next edge, with no issue pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instValid | input | 1 | A decoded instruction is offered |
| instMask | input | NUM_UNITS | Class bitmask of the offered instruction |
| instReady | output | 1 | Controller is idle and will accept |
| unitBusy | input | NUM_UNITS | Per-unit busy, held high through writeback |
| unitIssue | output | NUM_UNITS | Per-unit one-cycle issue strobe |
| illegalInst | output | 1 | One-cycle flag for an instruction that matches no unit |

## Verification
The hardest case to reach is one where the busy lines of the unselected units are held high throughout an instruction's life. A faulty controller that listens to the wrong unit would either never complete or complete too early. The stimulus table includes a vector that keeps every other busy bit asserted while only the selected unit toggles its bit, with a delay before busy rises. A further directed test asserts reset while the controller waits for busy to fall.

// File: rtl/dispatch_pkg.sv
package dispatch_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_ISSUE    = 3'd1,
    ST_WAITRISE = 3'd2,
    ST_WAITFALL = 3'd3,
    ST_FLAG     = 3'd4
  } ctrlState_t;

  typedef struct packed {
    logic latchEn;
    logic issueEn;
  } strobe_t;

endpackage

// File: rtl/dispatch_ctrl.sv
module dispatch_ctrl
  import dispatch_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    instValid,
  input  logic    anyMatch,
  input  logic    selBusy,
  output logic    instReady,
  output logic    illegalInst,
  output strobe_t strobes
);

  ctrlState_t stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE:     if (instValid) stateD = anyMatch ? ST_ISSUE : ST_FLAG;
      ST_ISSUE:    stateD = ST_WAITRISE;
      ST_WAITRISE: if (selBusy) stateD = ST_WAITFALL;
      ST_WAITFALL: if (!selBusy) stateD = ST_IDLE;
      ST_FLAG:     stateD = ST_IDLE;
      default:     stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) stateQ <= ST_IDLE;
    else     stateQ <= stateD;
  end

  assign instReady       = (stateQ == ST_IDLE);
  assign illegalInst     = (stateQ == ST_FLAG);
  assign strobes.latchEn = (stateQ == ST_IDLE) && instValid;
  assign strobes.issueEn = (stateQ == ST_ISSUE);

  // R7
  illegal_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    illegalInst |=> (!illegalInst && instReady));

  // R5
  wait_done_chk: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_WAITFALL && !selBusy) |=> instReady);

endmodule

// File: rtl/dispatch_path.sv
module dispatch_path
  import dispatch_pkg::*;
#(
  parameter int NUM_UNITS = 5,
  localparam int IDX_W = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  strobe_t              strobes,
  input  logic [NUM_UNITS-1:0] instMask,
  input  logic [NUM_UNITS-1:0] unitBusy,
  output logic                 anyMatch,
  output logic                 selBusy,
  output logic [NUM_UNITS-1:0] unitIssue
);

  logic [IDX_W-1:0] winIdx;
  logic [IDX_W-1:0] selIdxQ;

  // lowest set bit wins: scan from the top so the lowest overwrites
  always_comb begin
    winIdx = '0;
    for (int i = NUM_UNITS - 1; i >= 0; i--) begin
      if (instMask[i]) winIdx = IDX_W'(i);
    end
  end

  assign anyMatch = |instMask;

  always_ff @(posedge clk) begin
    if (rst)                  selIdxQ <= '0;
    else if (strobes.latchEn) selIdxQ <= winIdx;
  end

  always_comb begin
    selBusy = 1'b0;
    for (int i = 0; i < NUM_UNITS; i++) begin
      if (selIdxQ == IDX_W'(i)) selBusy = unitBusy[i];
    end
  end

  generate
    for (genvar g = 0; g < NUM_UNITS; g++) begin : g_issue
      assign unitIssue[g] = strobes.issueEn && (selIdxQ == IDX_W'(g));
    end
  endgenerate

  // R2
  issue_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(unitIssue));

  // R2
  issue_single_chk: assert property (@(posedge clk) disable iff (rst)
    (|unitIssue) |=> !(|unitIssue));

endmodule

// File: rtl/fu_dispatch.sv
module fu_dispatch
  import dispatch_pkg::*;
#(
  parameter int NUM_UNITS = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 instValid,
  input  logic [NUM_UNITS-1:0] instMask,
  output logic                 instReady,
  input  logic [NUM_UNITS-1:0] unitBusy,
  output logic [NUM_UNITS-1:0] unitIssue,
  output logic                 illegalInst
);

  strobe_t strobes;
  logic    anyMatch;
  logic    selBusy;

  dispatch_ctrl i_ctrl (
    .clk        (clk),
    .rst        (rst),
    .instValid  (instValid),
    .anyMatch   (anyMatch),
    .selBusy    (selBusy),
    .instReady  (instReady),
    .illegalInst(illegalInst),
    .strobes    (strobes)
  );

  dispatch_path #(.NUM_UNITS(NUM_UNITS)) i_path (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .instMask (instMask),
    .unitBusy (unitBusy),
    .anyMatch (anyMatch),
    .selBusy  (selBusy),
    .unitIssue(unitIssue)
  );

  // R2
  accept_issue_chk: assert property (@(posedge clk) disable iff (rst)
    (instValid && instReady && (|instMask)) |=> ($countones(unitIssue) == 1));

  // R7
  accept_illegal_chk: assert property (@(posedge clk) disable iff (rst)
    (instValid && instReady && !(|instMask)) |=> (illegalInst && !(|unitIssue)));

  // R1
  issue_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (|unitIssue) |-> !instReady);

endmodule

// File: tb/test_fu_dispatch.sv
module test_fu_dispatch;

  localparam int N = 5;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         instValid = 1'b0;
  logic [N-1:0] instMask = '0;
  logic         instReady;
  logic [N-1:0] unitBusy = '0;
  logic [N-1:0] unitIssue;
  logic         illegalInst;

  int compared = 0;
  int mismatched = 0;

  always #4 clk = ~clk;

  fu_dispatch #(.NUM_UNITS(N)) i_fu_dispatch (
    .clk        (clk),
    .rst        (rst),
    .instValid  (instValid),
    .instMask   (instMask),
    .instReady  (instReady),
    .unitBusy   (unitBusy),
    .unitIssue  (unitIssue),
    .illegalInst(illegalInst)
  );

  // fields: mask[20:16] idx[15:13] (7 = illegal) dly[12:9] len[8:5] other[4:0]
  localparam logic [20:0] VEC [11] = '{
    {5'b00001, 3'd0, 4'd0, 4'd1, 5'b00000},  // R3 arithmetic
    {5'b00010, 3'd1, 4'd2, 4'd3, 5'b00000},  // R3 logical
    {5'b00100, 3'd2, 4'd1, 4'd1, 5'b00000},  // R3 shift/rotate
    {5'b01000, 3'd3, 4'd0, 4'd4, 5'b00000},  // R3 condition
    {5'b10000, 3'd4, 4'd3, 4'd2, 5'b00000},  // R3 branch
    {5'b10110, 3'd1, 4'd0, 4'd2, 5'b00000},  // R4
    {5'b11000, 3'd3, 4'd1, 4'd1, 5'b00000},  // R4
    {5'b11111, 3'd0, 4'd2, 4'd1, 5'b00000},  // R4
    {5'b00000, 3'd7, 4'd0, 4'd0, 5'b00000},  // R7
    {5'b10000, 3'd4, 4'd5, 4'd2, 5'b01111},  // R6
    {5'b00100, 3'd2, 4'd2, 4'd3, 5'b11011}   // R6
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic runOne(input logic [N-1:0] mask, input int idx, input int dly,
                        input int len, input logic [N-1:0] other);
    logic [N-1:0] selBit;
    selBit = (idx < N) ? (N'(1) << idx) : '0;
    @(negedge clk);
    unitBusy = other & ~selBit;
    chk("R1 ready when idle", 32'(instReady), 1);
    instValid = 1'b1;
    instMask  = mask;
    @(negedge clk);
    instValid = 1'b0;
    if (idx == 7) begin
      chk("R7 flag raised", 32'(illegalInst), 1);
      chk("R7 no issue", 32'(unitIssue), 0);
      chk("R7 not ready", 32'(instReady), 0);
      @(negedge clk);
      chk("R7 flag one cycle", 32'(illegalInst), 0);
      chk("R7 ready again", 32'(instReady), 1);
    end else begin
      chk("R3 R4 issued unit", 32'(unitIssue), 32'(selBit));
      chk("R1 not ready while issuing", 32'(instReady), 0);
      @(negedge clk);
      chk("R2 issue one cycle", 32'(unitIssue), 0);
      for (int k = 0; k < dly; k++) begin
        @(negedge clk);
        chk("R5 waits for busy rise", 32'(instReady), 0);
      end
      unitBusy = unitBusy | selBit;
      for (int k = 0; k < len; k++) begin
        @(negedge clk);
        chk("R5 not ready while busy", 32'(instReady), 0);
        chk("R2 no reissue", 32'(unitIssue), 0);
      end
      unitBusy = unitBusy & ~selBit;
      @(negedge clk);
      chk("R5 ready after busy falls", 32'(instReady), 1);
      chk("R6 other busy ignored", 32'(instReady), 1);
    end
    unitBusy = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 reset ready", 32'(instReady), 1);
    chk("R1 reset issue", 32'(unitIssue), 0);
    chk("R1 reset illegal", 32'(illegalInst), 0);

    for (int v = 0; v < 11; v++) begin
      runOne(VEC[v][20:16], int'(VEC[v][15:13]), int'(VEC[v][12:9]),
             int'(VEC[v][8:5]), VEC[v][4:0]);
    end

    // R5: valid held high while a unit is in flight is not taken
    @(negedge clk);
    instValid = 1'b1;
    instMask  = 5'b01000;
    @(negedge clk);
    instMask  = 5'b00001;
    chk("R3 condition unit issued", 32'(unitIssue), 32'h08);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R5 held valid not taken", 32'(instReady), 0);
      chk("R5 no issue while waiting", 32'(unitIssue), 0);
    end
    unitBusy = 5'b01000;
    @(negedge clk);
    unitBusy = 5'b00000;
    @(negedge clk);
    chk("R5 ready then accepts", 32'(instReady), 1);
    @(negedge clk);
    instValid = 1'b0;
    chk("R3 next instruction issued", 32'(unitIssue), 32'h01);
    @(negedge clk);
    unitBusy = 5'b00001;
    @(negedge clk);
    unitBusy = 5'b00000;
    @(negedge clk);
    chk("R5 second completes", 32'(instReady), 1);

    // R8: reset while waiting for busy to fall
    instValid = 1'b1;
    instMask  = 5'b00100;
    @(negedge clk);
    instValid = 1'b0;
    @(negedge clk);
    unitBusy = 5'b00100;
    @(negedge clk);
    chk("R8 waiting before reset", 32'(instReady), 0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R8 ready after reset", 32'(instReady), 1);
    chk("R8 no issue after reset", 32'(unitIssue), 0);
    chk("R8 no flag after reset", 32'(illegalInst), 0);
    unitBusy = '0;
    @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule